// File: doc/BRIEF.md
# Decimating FIR Filter with Offset-Binary Output

This block sits between a parallel 16-bit converter interface and a parallel current-output DAC. Incoming two's-complement samples first pass a programmable rate reducer that keeps one sample out of every N accepted samples. A factor of 1 keeps all of them. The kept samples feed a direct-form FIR filter whose coefficients are build-time constants. The filter therefore works at the reduced rate and not at the converter rate.

Each filter result is rounded, clamped to 16 bits and recoded to straight binary for the DAC. The rate factor is held in an internal register. A load strobe writes it, and the same write restarts the keep/drop sequence. A generate option selects either a plain multiply-accumulate over every tap or a folded form. The folded form pre-adds mirrored taps of the symmetric coefficient set.

Top module: `decim_fir_dac`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0x8000, the factor register holds 1, and every filter delay stage holds zero. The first outputs after reset therefore see zeros as history.
- R2: With factor 1, every accepted input sample (in_valid high) produces exactly one output.
- R3: With factor N, the first accepted sample after reset or after a factor load is kept, and then every Nth accepted sample is kept. A load in the same cycle as an accepted sample applies the new factor, and that sample is kept as the first of the new sequence. A loaded value of 0 acts as 1.
- R4: The full-precision result is acc = sum over i of b_i * x[n-i], for i from 0 to TAPS-1. The coefficients are b_i = STEP * (min(i, TAPS-1-i) + 1), with 15 fraction bits. With the defaults (TAPS 5, STEP 4096) they are 4096, 8192, 12288, 8192, 4096.
- R5: Rounding adds 2^14 to acc and shifts right arithmetically by 15. Ties therefore round toward plus infinity: +0.5 becomes 1 and -0.5 becomes 0.
- R6: The rounded value is clamped to the range -32768 to +32767.
- R7: out_data is the clamped value with its bit 15 inverted: -32768 gives 0x0000, 0 gives 0x8000, and +32767 gives 0xFFFF.
- R8: out_valid is a one-cycle pulse for each kept sample. It is high in the cycle after the fourth rising edge, counting the edge that accepted the kept sample. It is low in all other cycles.
- R9: Dropped samples do not enter the delay line. Only kept samples form the history x[n-i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Two's-complement sample |
| fact_ld | input | 1 | Load strobe for the rate factor |
| fact_val | input | 8 | Rate factor value |
| out_valid | output | 1 | Result strobe |
| out_data | output | 16 | Straight-binary result for the DAC |

## Verification
Two functions can fall in the same cycle: a factor load and an accepted sample. The load must restart the sequence, and the simultaneous sample must be kept under the new factor. The bench provokes this by raising fact_ld together with in_valid in the middle of streams of different lengths and factors. A cycle-exact model in the bench judges the result: it applies the same keep rule and predicts the rounded, clamped and recoded value. Each prediction is due on a specific cycle, and out_valid is checked as low on every other cycle.

// File: rtl/dfd_pkg.sv
package dfd_pkg;
   // symmetric triangular coefficient set
   function automatic int tap_coef(input int i, input int taps, input int step);
      int m;
      m = (i < taps - 1 - i) ? i : taps - 1 - i;
      return step * (m + 1);
   endfunction
endpackage

// File: rtl/rate_reducer.sv
module rate_reducer #(
   parameter int SMP_W  = 16,
   parameter int FACT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SMP_W-1:0] in_data,
   input  logic             fact_ld,
   input  logic [FACT_W-1:0] fact_val,
   output logic             dec_v,
   output logic [SMP_W-1:0] dec_d
);
   logic [FACT_W-1:0] fact_q, cnt_q;
   logic [FACT_W-1:0] f_now, c_now, c_nxt;
   logic              keep;

   always_comb begin
      f_now = fact_ld ? ((fact_val == '0) ? FACT_W'(1) : fact_val) : fact_q;
      c_now = fact_ld ? '0 : cnt_q;
      keep  = in_valid && (c_now == '0);
      if (in_valid)
         c_nxt = (c_now == f_now - FACT_W'(1)) ? '0 : c_now + FACT_W'(1);
      else
         c_nxt = c_now;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fact_q <= FACT_W'(1);
         cnt_q  <= '0;
         dec_v  <= 1'b0;
         dec_d  <= '0;
      end else begin
         fact_q <= f_now;
         cnt_q  <= c_nxt;
         dec_v  <= keep;
         if (keep) dec_d <= in_data;
      end
   end

   // R3: phase counter stays below the active factor
   p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < fact_q);
   // R3: a load together with a sample keeps that sample
   p_keep_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fact_ld && in_valid) |=> dec_v);
   // R2: factor one forwards every sample unchanged
   p_pass_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !fact_ld && fact_q == FACT_W'(1)) |=> (dec_v && dec_d == $past(in_data)));
endmodule

// File: rtl/fir_direct.sv
module fir_direct
   import dfd_pkg::*;
#(
   parameter int SMP_W  = 16,
   parameter int COEF_W = 16,
   parameter int TAPS   = 5,
   parameter int STEP   = 4096,
   parameter bit FOLD   = 1'b1,
   parameter int ACC_W  = SMP_W + COEF_W + $clog2(TAPS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    s_v,
   input  logic [SMP_W-1:0]        s_d,
   output logic                    acc_v,
   output logic signed [ACC_W-1:0] acc
);
   localparam int HALF = TAPS / 2;

   logic signed [SMP_W-1:0]  dl [TAPS];
   logic signed [COEF_W-1:0] bq [TAPS];
   logic                     tap_v;
   logic signed [ACC_W-1:0]  sum;

   for (genvar i = 0; i < TAPS; i++) begin : g_tap
      localparam logic signed [COEF_W-1:0] B = COEF_W'(tap_coef(i, TAPS, STEP));
      assign bq[i] = B;
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n)   dl[0] <= '0;
            else if (s_v) dl[0] <= s_d;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n)   dl[i] <= '0;
            else if (s_v) dl[i] <= dl[i-1];
         end
      end
   end

   if (FOLD) begin : g_folded
      always_comb begin
         sum = '0;
         for (int k = 0; k < HALF; k++)
            sum += (ACC_W'(dl[k]) + ACC_W'(dl[TAPS-1-k])) * ACC_W'(bq[k]);
         if (TAPS % 2 == 1)
            sum += ACC_W'(dl[HALF]) * ACC_W'(bq[HALF]);
      end
   end else begin : g_plain
      always_comb begin
         sum = '0;
         for (int k = 0; k < TAPS; k++)
            sum += ACC_W'(dl[k]) * ACC_W'(bq[k]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tap_v <= 1'b0;
         acc_v <= 1'b0;
         acc   <= '0;
      end else begin
         tap_v <= s_v;
         acc_v <= tap_v;
         if (tap_v) acc <= sum;
      end
   end

   // R8: every line update yields one result a cycle later
   p_tap_to_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tap_v |=> acc_v);
   // R9: only kept samples enter the line
   p_line_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      s_v |=> dl[0] == $past(s_d));
   p_line_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !s_v |=> $stable(dl[TAPS-1]));
endmodule

// File: rtl/out_recode.sv
module out_recode #(
   parameter int SMP_W = 16,
   parameter int FRAC  = 15,
   parameter int ACC_W = 35
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    acc_v,
   input  logic signed [ACC_W-1:0] acc,
   output logic                    out_valid,
   output logic [SMP_W-1:0]        out_data
);
   localparam logic signed [ACC_W-1:0] RND = ACC_W'(64'sd1 <<< (FRAC - 1));
   localparam logic signed [ACC_W-1:0] HI  = ACC_W'((64'sd1 <<< (SMP_W - 1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] LO  = -HI - ACC_W'(1);

   logic signed [ACC_W-1:0] sh;
   logic [SMP_W-1:0]        clamped;

   always_comb begin
      sh = (acc + RND) >>> FRAC;
      if (sh > HI)      clamped = {1'b0, {(SMP_W-1){1'b1}}};
      else if (sh < LO) clamped = {1'b1, {(SMP_W-1){1'b0}}};
      else              clamped = sh[SMP_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= {1'b1, {(SMP_W-1){1'b0}}};
      end else begin
         out_valid <= acc_v;
         if (acc_v) out_data <= {~clamped[SMP_W-1], clamped[SMP_W-2:0]};
      end
   end

   // R8: result strobe follows the accumulator strobe by one cycle
   p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_v |=> out_valid);
   p_valid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_v |=> !out_valid);
   // R6: clamping at both ends
   p_sat_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_v && sh > HI) |=> out_data == '1);
   p_sat_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_v && sh < LO) |=> out_data == '0);
endmodule

// File: rtl/decim_fir_dac.sv
module decim_fir_dac
   import dfd_pkg::*;
#(
   parameter int SMP_W  = 16,
   parameter int COEF_W = 16,
   parameter int FRAC   = 15,
   parameter int TAPS   = 5,
   parameter int STEP   = 4096,
   parameter int FACT_W = 8,
   parameter bit FOLD   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [SMP_W-1:0]  in_data,
   input  logic              fact_ld,
   input  logic [FACT_W-1:0] fact_val,
   output logic              out_valid,
   output logic [SMP_W-1:0]  out_data
);
   localparam int ACC_W = SMP_W + COEF_W + $clog2(TAPS + 1);

   initial begin
      a_taps_min: assert (TAPS >= 2) else $error("TAPS too small");
      a_frac_rng: assert (FRAC >= 1 && FRAC < ACC_W) else $error("FRAC out of range");
      a_fact_w:   assert (FACT_W >= 1) else $error("FACT_W too small");
      a_coef_fit: assert (tap_coef(TAPS / 2, TAPS, STEP) < (1 <<< (COEF_W - 1)))
         else $error("coefficient exceeds COEF_W");
   end

   logic             dec_v;
   logic [SMP_W-1:0] dec_d;
   logic             acc_v;
   logic signed [ACC_W-1:0] acc;

   rate_reducer #(.SMP_W(SMP_W), .FACT_W(FACT_W)) u_rate (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .fact_ld(fact_ld), .fact_val(fact_val), .dec_v(dec_v), .dec_d(dec_d));

   fir_direct #(.SMP_W(SMP_W), .COEF_W(COEF_W), .TAPS(TAPS), .STEP(STEP),
                .FOLD(FOLD), .ACC_W(ACC_W)) u_fir (
      .clk(clk), .rst_n(rst_n), .s_v(dec_v), .s_d(dec_d),
      .acc_v(acc_v), .acc(acc));

   out_recode #(.SMP_W(SMP_W), .FRAC(FRAC), .ACC_W(ACC_W)) u_out (
      .clk(clk), .rst_n(rst_n), .acc_v(acc_v), .acc(acc),
      .out_valid(out_valid), .out_data(out_data));
endmodule

// File: tb/sim_decim_fir_dac.sv
module sim_decim_fir_dac;
   localparam int CLK_PERIOD = 10;
   localparam int TAPS = 5;
   localparam int STEP = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic fact_ld = 1'b0;
   logic [7:0] fact_val = '0;
   logic out_valid;
   logic [15:0] out_data;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;
   string cur_req = "R4";

   longint hist [TAPS];
   int m_fact = 1, m_cnt = 0;
   int due_q [$];
   int exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   decim_fir_dac u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .fact_ld(fact_ld), .fact_val(fact_val), .out_valid(out_valid), .out_data(out_data));

   function automatic longint coef(input int i);
      int m;
      m = (i < TAPS - 1 - i) ? i : TAPS - 1 - i;
      return longint'(STEP * (m + 1));
   endfunction

   function automatic int expect_out();
      longint acc, r;
      acc = 0;
      for (int i = 0; i < TAPS; i++) acc += coef(i) * hist[i];
      r = (acc + 64'sd16384) >>> 15;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      return int'((r + 32768) & 16'hFFFF);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp_v);
      end
   endtask

   task automatic check_out();
      if (due_q.size() > 0 && due_q[0] == cyc) begin
         chk(out_valid === 1'b1, "R8", int'(out_valid), 1);
         chk(out_data === 16'(exp_q[0]), cur_req, int'(out_data), exp_q[0]);
         void'(due_q.pop_front());
         void'(exp_q.pop_front());
      end else begin
         chk(out_valid === 1'b0, "R8", int'(out_valid), 0);
      end
   endtask

   task automatic tick(input bit v, input int d, input bit ld, input int f);
      int fn, cn;
      @(negedge clk);
      cyc++;
      check_out();
      in_valid = v; in_data = 16'(d); fact_ld = ld; fact_val = 8'(f);
      fn = ld ? ((f == 0) ? 1 : f) : m_fact;
      cn = ld ? 0 : m_cnt;
      if (v) begin
         if (cn == 0) begin
            for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = longint'(d);
            due_q.push_back(cyc + 4);
            exp_q.push_back(expect_out());
         end
         cn = (cn == fn - 1) ? 0 : cn + 1;
      end
      m_fact = fn; m_cnt = cn;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) tick(0, 0, 0, 0);
   endtask

   initial begin
      int lf;
      for (int i = 0; i < TAPS; i++) hist[i] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_valid === 1'b0, "R1", int'(out_valid), 0);
      chk(out_data === 16'h8000, "R1", int'(out_data), 16'h8000);
      @(negedge clk); rst_n = 1'b1;
      // R1 R2 R4: impulse at factor one over zero history
      cur_req = "R4";
      tick(1, 1000, 0, 0);
      for (int k = 0; k < 6; k++) tick(1, 0, 0, 0);
      idle(6);
      // R5: rounding ties and fractions
      cur_req = "R5";
      tick(1, 4, 0, 0); for (int k = 0; k < 5; k++) tick(1, 0, 0, 0);
      tick(1, -4, 0, 0); for (int k = 0; k < 5; k++) tick(1, 0, 0, 0);
      tick(1, 1, 0, 0); for (int k = 0; k < 5; k++) tick(1, 0, 0, 0);
      idle(6);
      // R6 R7: positive and negative steps saturate; zero gives mid-scale
      cur_req = "R6";
      for (int k = 0; k < 8; k++) tick(1, 32767, 0, 0);
      for (int k = 0; k < 8; k++) tick(1, -32768, 0, 0);
      cur_req = "R7";
      for (int k = 0; k < 8; k++) tick(1, 0, 0, 0);
      idle(6);
      // R3 R9: factor four, ramp input, impulse and step
      cur_req = "R3";
      tick(1, 100, 1, 4);
      for (int k = 1; k < 24; k++) tick(1, 100 * (k + 1), 0, 0);
      cur_req = "R9";
      tick(1, 5000, 1, 4);
      for (int k = 0; k < 19; k++) tick(1, (k % 4 == 2) ? 30000 : 0, 0, 0);
      for (int k = 0; k < 20; k++) tick(1, 20000, 0, 0);
      idle(6);
      // R3: load in the middle with a coincident sample, gaps, factor 0
      cur_req = "R3";
      tick(1, 7, 1, 3); tick(1, 9, 0, 0); tick(0, 0, 0, 0); tick(1, 11, 0, 0);
      tick(1, 13, 0, 0); tick(1, 1500, 1, 2); tick(0, 0, 0, 0); tick(1, 17, 0, 0);
      tick(1, 2500, 0, 0);
      tick(1, -900, 1, 0);
      for (int k = 0; k < 8; k++) tick(1, 300 * k - 1000, 0, 0);
      idle(6);
      // near-exhaustive sweep of factors with pseudo-random data and gaps
      cur_req = "R4";
      lf = 16'hACE1;
      for (int f = 1; f <= 6; f++) begin
         tick(0, 0, 1, f);
         for (int k = 0; k < 60; k++) begin
            lf = ((lf << 1) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1)) & 16'hFFFF;
            tick((lf & 7) != 0, (lf >= 32768) ? lf - 65536 : lf, (k == 31), f + 1);
         end
      end
      idle(8);
      chk(due_q.size() == 0, "R8", due_q.size(), 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R8 watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule